// File: doc/BRIEF.md
# Five-Segment Charge Bar Display Driver

This block turns a battery's available-charge count into a five-LED bar and a 4-bit gauge value. The full-scale reference comes from one of two sources. In relative mode it is the learned capacity. In absolute mode it is the programmed capacity. The displayed fraction is reduced in cold conditions through three temperature bands, and the band boundary at 0 °C has hysteresis. A separate low-battery warning makes the first segment blink.

The LEDs are driven in two interleaved banks, each lit for a short slot of a repeating frame, so the two banks never draw current together. The bar is shown only while one of three conditions holds: a button-started hold window, a charge-display request, or a fast-discharge request. A strap input forces the bar dark. A test register can take over the five outputs directly. The frame, the blink and the hold window all count ticks from one shared prescaler.

Top module: `cap_bar_display`

## Requirements
- R1: `gauge` equals min(15, floor(16·E/F)), where F is `prog_cap` when `abs_mode`=1 and `learned_cap` otherwise, and E is the derated charge from R2. It updates one clock after `avail_chg` or the reference changes.
- R2: The temperature band selects E. Above the cold zone E = `avail_chg`. In the cold band E = 3/4 of `avail_chg`. In the frozen band E = 1/2 of `avail_chg`. `temp_c` (signed °C) below -20 selects frozen, and -20..-1 selects cold. `temp_c` ≥ 4 selects normal. For 0..3 the band is kept, except that frozen moves to cold. The band is registered, so a temperature change reaches `gauge` two clocks later.
- R3: Segment i (i = 1..5, `seg_drv` bit i-1) is lit when 5·E > (i-1)·F.
- R4: A frame has MUX_SLOTS ticks. Segments 1, 3 and 5 (bits 0, 2, 4) may be driven only in slots 0..ON_SLOTS-1. Segments 2 and 4 may be driven only in slots MUX_SLOTS/2 .. MUX_SLOTS/2+ON_SLOTS-1. The two banks are never driven in the same cycle.
- R5: The bar is shown only while the hold window is open, `chg_show`=1 or `fast_dis`=1. `show_off`=1 blanks all segments.
- R6: A high-to-low transition on `btn_n` opens the hold window for HOLD_TICKS ticks. A further transition restarts the window, and holding `btn_n` low does not extend it.
- R7: When 10·E < F or `empty_flag`=1, segment 1 ignores its fraction and follows a blink phase that toggles every BLINK_TICKS ticks, starting on. The bank and enable gating still apply.
- R8: When `ovr_reg` bit 0 is 1, `seg_drv` equals `ovr_reg`[5:1] on every cycle, one clock later. This bypasses the gauge, the multiplexing, the enables and `show_off`. Bits 7:6 are ignored.
- R9: While `rst` is high, `seg_drv` and `gauge` are 0, the band is normal and the hold window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| avail_chg | input | CHG_W | Available charge count |
| learned_cap | input | CHG_W | Learned capacity, relative-mode reference |
| prog_cap | input | CHG_W | Programmed capacity, absolute-mode reference |
| abs_mode | input | 1 | 1 selects the programmed reference |
| temp_c | input | 8 | Signed temperature in °C |
| empty_flag | input | 1 | End-of-discharge condition |
| btn_n | input | 1 | Display button, active low |
| chg_show | input | 1 | Charging above the display rate |
| fast_dis | input | 1 | Fast discharge in progress |
| show_off | input | 1 | Display disable strap |
| ovr_reg | input | 8 | Test override: bit 0 enable, bits 5:1 segments 5..1 |
| seg_drv | output | 5 | Segment drive, bit 0 = segment 1 |
| gauge | output | 4 | Fraction in sixteenths, 0..15 |

## Verification
A wrong band state shows within two clocks as a `gauge` of 12 or 8 where 15 is expected. This is why the hysteresis walk reads `gauge` after every temperature step. A comparator or reference-select error shows one clock after the input change, in `gauge` and in the set of segments seen over one frame. Counter faults in the frame, blink or hold window show only over many ticks. They appear as per-frame on-cycle counts other than ON_SLOTS·TICK_DIV, a blinking segment lit as often as a steady one, or a bar that stays lit past the hold window. Each of these needs one full frame, blink period or hold window of observation.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

    localparam int SEGS        = 5;
    localparam int GAUGE_W     = 4;
    localparam int GAUGE_STEPS = 16;

    typedef enum logic [1:0] {
        BAND_NORM   = 2'd0,
        BAND_COLD   = 2'd1,
        BAND_FROZEN = 2'd2
    } band_e;

    typedef struct packed {
        logic [GAUGE_W-1:0] level;
        logic [SEGS-1:0]    lit;
        logic               low;
    } gauge_t;

    // Next temperature band; 0..hyst-1 keeps the previous band (frozen relaxes to cold)
    function automatic band_e band_step(input band_e cur, input logic signed [7:0] t, input int hyst);
        band_e nb;
        if (t < -8'sd20)
            nb = BAND_FROZEN;
        else if (t < 8'sd0)
            nb = BAND_COLD;
        else if (int'(t) >= hyst)
            nb = BAND_NORM;
        else if (cur == BAND_FROZEN)
            nb = BAND_COLD;
        else
            nb = cur;
        return nb;
    endfunction

endpackage

// File: rtl/cbd_timebase.sv
module cbd_timebase #(
    parameter int TICK_DIV    = 312,
    parameter int MUX_SLOTS   = 10,
    parameter int BLINK_TICKS = 400,
    parameter int HOLD_TICKS  = 12800,
    localparam int SW = $clog2(MUX_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          btn_n,
    output logic [SW-1:0] slot,
    output logic          blink_on,
    output logic          hold_on
);
    localparam int DW = $clog2(TICK_DIV + 1);
    localparam int BW = $clog2(BLINK_TICKS + 1);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    logic [DW-1:0] div_cnt;
    logic [BW-1:0] blink_cnt;
    logic [HW-1:0] hold_cnt;
    logic          tick;
    logic          btn_q;
    logic          btn_fall;

    assign tick     = (div_cnt == DW'(TICK_DIV - 1));
    assign btn_fall = btn_q && !btn_n;
    assign hold_on  = (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)       div_cnt <= '0;
        else if (tick) div_cnt <= '0;
        else           div_cnt <= div_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (tick) begin
            if (slot == SW'(MUX_SLOTS - 1)) slot <= '0;
            else                            slot <= slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blink_cnt <= '0;
            blink_on  <= 1'b1;
        end else if (tick) begin
            if (blink_cnt == BW'(BLINK_TICKS - 1)) begin
                blink_cnt <= '0;
                blink_on  <= !blink_on;
            end else begin
                blink_cnt <= blink_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            btn_q    <= 1'b1;
            hold_cnt <= '0;
        end else begin
            btn_q <= btn_n;
            if (btn_fall)
                hold_cnt <= HW'(HOLD_TICKS);
            else if (tick && hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    AST_HOLD_START: assert property (@(posedge clk) disable iff (rst)
        (btn_q && !btn_n) |=> hold_on);                                   // R6
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(slot) < MUX_SLOTS);                                           // R4
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(hold_cnt) <= HOLD_TICKS);                                     // R6

endmodule

// File: rtl/cbd_gauge.sv
module cbd_gauge
    import cbd_pkg::*;
#(
    parameter int CHG_W = 16,
    parameter int HYST  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHG_W-1:0]  chg,
    input  logic [CHG_W-1:0]  full_ref,
    input  logic signed [7:0] temp_c,
    output gauge_t            g_q,
    output band_e             band_q
);
    localparam int PW = CHG_W + 6;

    logic [PW-1:0] scaled;      // 4 x derated charge
    logic [PW-1:0] ref_x;
    logic [GAUGE_STEPS-1:1] step_ge;
    logic [SEGS-1:0] lit_d;
    logic [GAUGE_W-1:0] level_d;
    logic low_d;

    assign ref_x = PW'(full_ref);

    always_comb begin
        unique case (band_q)
            BAND_COLD:   scaled = PW'(chg) * PW'(3);
            BAND_FROZEN: scaled = PW'(chg) << 1;
            default:     scaled = PW'(chg) << 2;
        endcase
    end

    for (genvar k = 1; k < GAUGE_STEPS; k++) begin : g_step
        assign step_ge[k] = (scaled << 2) >= (ref_x * PW'(k));
    end

    for (genvar i = 0; i < SEGS; i++) begin : g_seg
        assign lit_d[i] = (scaled * PW'(5)) > (ref_x * PW'(4 * i));
    end

    assign low_d = (scaled * PW'(10)) < (ref_x << 2);

    always_comb begin
        level_d = '0;
        for (int k = 1; k < GAUGE_STEPS; k++)
            level_d = level_d + GAUGE_W'(step_ge[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            band_q <= BAND_NORM;
            g_q    <= '0;
        end else begin
            band_q   <= band_step(band_q, temp_c, HYST);
            g_q.level <= level_d;
            g_q.lit   <= lit_d;
            g_q.low   <= low_d;
        end
    end

    AST_FROZEN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (temp_c < -8'sd20) |=> (band_q == BAND_FROZEN));                   // R2
    AST_NORM_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (int'(temp_c) >= HYST) |=> (band_q == BAND_NORM));                 // R2
    AST_BAND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (temp_c >= 8'sd0 && int'(temp_c) < HYST && band_q != BAND_FROZEN)
        |=> $stable(band_q));                                              // R2
    AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (band_q == BAND_NORM && full_ref != '0 && chg >= full_ref)
        |=> (g_q.level == 4'd15 && &g_q.lit));                             // R1

endmodule

// File: rtl/cbd_frame.sv
module cbd_frame
    import cbd_pkg::*;
#(
    parameter int MUX_SLOTS = 10,
    parameter int ON_SLOTS  = 3,
    localparam int SW = $clog2(MUX_SLOTS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SEGS-1:0] lit,
    input  logic            low,
    input  logic            empty_flag,
    input  logic [SW-1:0]   slot,
    input  logic            blink_on,
    input  logic            hold_on,
    input  logic            chg_show,
    input  logic            fast_dis,
    input  logic            show_off,
    input  logic [7:0]      ovr_reg,
    output logic [SEGS-1:0] seg_q
);
    localparam int HALF = MUX_SLOTS / 2;

    logic bank_a_on, bank_b_on, shown, warn;
    logic [SEGS-1:0] drive;

    assign bank_a_on = int'(slot) < ON_SLOTS;
    assign bank_b_on = int'(slot) >= HALF && int'(slot) < HALF + ON_SLOTS;
    assign shown     = (hold_on || chg_show || fast_dis) && !show_off;
    assign warn      = low || empty_flag;

    for (genvar i = 0; i < SEGS; i++) begin : g_drv
        logic want, bank_ok;
        if (i == 0) begin : g_first
            assign want = warn ? blink_on : lit[0];
        end else begin : g_rest
            assign want = lit[i];
        end
        if (i % 2 == 0) begin : g_bank_a
            assign bank_ok = bank_a_on;
        end else begin : g_bank_b
            assign bank_ok = bank_b_on;
        end
        assign drive[i] = want && bank_ok && shown;
    end

    always_ff @(posedge clk) begin
        if (rst)             seg_q <= '0;
        else if (ovr_reg[0]) seg_q <= ovr_reg[5:1];
        else                 seg_q <= drive;
    end

    AST_BANK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !ovr_reg[0] |=> !(|(seg_q & 5'b10101) && |(seg_q & 5'b01010)));    // R4
    AST_OVR_PASS: assert property (@(posedge clk) disable iff (rst)
        ovr_reg[0] |=> (seg_q == $past(ovr_reg[5:1])));                    // R8
    AST_OFF_DARK: assert property (@(posedge clk) disable iff (rst)
        (show_off && !ovr_reg[0]) |=> (seg_q == '0));                      // R5
    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        (!hold_on && !chg_show && !fast_dis && !ovr_reg[0]) |=> (seg_q == '0)); // R5

endmodule

// File: rtl/cap_bar_display.sv
module cap_bar_display
    import cbd_pkg::*;
#(
    parameter int CHG_W       = 16,
    parameter int HYST        = 4,
    parameter int TICK_DIV    = 312,
    parameter int MUX_SLOTS   = 10,
    parameter int ON_SLOTS    = 3,
    parameter int BLINK_TICKS = 400,
    parameter int HOLD_TICKS  = 12800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHG_W-1:0]  avail_chg,
    input  logic [CHG_W-1:0]  learned_cap,
    input  logic [CHG_W-1:0]  prog_cap,
    input  logic              abs_mode,
    input  logic signed [7:0] temp_c,
    input  logic              empty_flag,
    input  logic              btn_n,
    input  logic              chg_show,
    input  logic              fast_dis,
    input  logic              show_off,
    input  logic [7:0]        ovr_reg,
    output logic [4:0]        seg_drv,
    output logic [3:0]        gauge
);
    localparam int SW = $clog2(MUX_SLOTS);

    logic [CHG_W-1:0] full_ref;
    logic [SW-1:0]    slot;
    logic             blink_on, hold_on;
    gauge_t           g_q;
    band_e            band_q;

    assign full_ref = abs_mode ? prog_cap : learned_cap;
    assign gauge    = g_q.level;

    cbd_timebase #(
        .TICK_DIV(TICK_DIV), .MUX_SLOTS(MUX_SLOTS),
        .BLINK_TICKS(BLINK_TICKS), .HOLD_TICKS(HOLD_TICKS)
    ) u_time (
        .clk(clk), .rst(rst), .btn_n(btn_n),
        .slot(slot), .blink_on(blink_on), .hold_on(hold_on)
    );

    cbd_gauge #(.CHG_W(CHG_W), .HYST(HYST)) u_gauge (
        .clk(clk), .rst(rst), .chg(avail_chg), .full_ref(full_ref),
        .temp_c(temp_c), .g_q(g_q), .band_q(band_q)
    );

    cbd_frame #(.MUX_SLOTS(MUX_SLOTS), .ON_SLOTS(ON_SLOTS)) u_frame (
        .clk(clk), .rst(rst), .lit(g_q.lit), .low(g_q.low),
        .empty_flag(empty_flag), .slot(slot), .blink_on(blink_on),
        .hold_on(hold_on), .chg_show(chg_show), .fast_dis(fast_dis),
        .show_off(show_off), .ovr_reg(ovr_reg), .seg_q(seg_drv)
    );

    AST_RESET_DARK: assert property (@(posedge clk)
        rst |=> (seg_drv == '0 && gauge == '0));                           // R9

endmodule

// File: tb/sim_cap_bar_display.sv
`timescale 1ns/1ps
module sim_cap_bar_display;

    localparam int TD = 2, MS = 10, ON = 3, BT = 20, HT = 60;
    localparam int FRAME = TD * MS;

    logic clk = 0, rst = 1;
    logic [15:0] avail_chg = 0, learned_cap = 0, prog_cap = 0;
    logic abs_mode = 0;
    logic signed [7:0] temp_c = 8'sd25;
    logic empty_flag = 0, btn_n = 1, chg_show = 0, fast_dis = 0, show_off = 0;
    logic [7:0] ovr_reg = 0;
    logic [4:0] seg_drv;
    logic [3:0] gauge;

    int total = 0, bad = 0;

    always #2 clk = ~clk;

    cap_bar_display #(
        .TICK_DIV(TD), .MUX_SLOTS(MS), .ON_SLOTS(ON),
        .BLINK_TICKS(BT), .HOLD_TICKS(HT)
    ) u0 (.*);

    typedef struct packed {
        logic        absm;
        logic [15:0] nac;
        logic [15:0] lcap;
        logic [15:0] pcap;
        logic signed [7:0] temp;
        logic [3:0]  g;
        logic [4:0]  lit;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 16'd500,  16'd1000, 16'd2000, 8'sd25,  4'd8,  5'b00111},
        '{1'b1, 16'd500,  16'd1000, 16'd2000, 8'sd25,  4'd4,  5'b00011},
        '{1'b0, 16'd1000, 16'd1000, 16'd2000, 8'sd25,  4'd15, 5'b11111},
        '{1'b0, 16'd1000, 16'd1000, 16'd2000, -8'sd10, 4'd12, 5'b01111},
        '{1'b0, 16'd1000, 16'd1000, 16'd2000, -8'sd30, 4'd8,  5'b00111},
        '{1'b1, 16'd3000, 16'd1000, 16'd2000, 8'sd30,  4'd15, 5'b11111},
        '{1'b0, 16'd199,  16'd1000, 16'd2000, 8'sd25,  4'd3,  5'b00001},
        '{1'b0, 16'd201,  16'd1000, 16'd2000, 8'sd25,  4'd3,  5'b00011},
        '{1'b0, 16'd125,  16'd1000, 16'd2000, 8'sd25,  4'd2,  5'b00001},
        '{1'b1, 16'd1875, 16'd1000, 16'd2000, 8'sd50,  4'd15, 5'b11111}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic observe(input int n, output logic [4:0] orv,
                           output int c0, output int c1, output bit ovl);
        orv = 0; c0 = 0; c1 = 0; ovl = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            orv |= seg_drv;
            if (seg_drv[0]) c0++;
            if (seg_drv[1]) c1++;
            if (|(seg_drv & 5'b10101) && |(seg_drv & 5'b01010)) ovl = 1;
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [4:0] orv;
        int c0, c1;
        bit ovl;

        // R9: reset state
        idle(5);
        chk("R9 seg_drv in reset", int'(seg_drv), 0);
        chk("R9 gauge in reset", int'(gauge), 0);
        rst = 0;
        observe(FRAME, orv, c0, c1, ovl);
        chk("R9 dark after reset, no enable", int'(orv), 0);

        // R1 R2 R3 R4: vector table
        chg_show = 1;
        for (int v = 0; v < 10; v++) begin
            abs_mode = VECS[v].absm; avail_chg = VECS[v].nac;
            learned_cap = VECS[v].lcap; prog_cap = VECS[v].pcap;
            temp_c = VECS[v].temp;
            idle(4);
            chk($sformatf("R1 gauge vec%0d", v), int'(gauge), int'(VECS[v].g));
            observe(FRAME, orv, c0, c1, ovl);
            chk($sformatf("R3 lit vec%0d", v), int'(orv), int'(VECS[v].lit));
            chk($sformatf("R4 no bank overlap vec%0d", v), int'(ovl), 0);
        end

        // R4: per-frame duty of each bank, all segments lit
        abs_mode = 0; avail_chg = 1000; learned_cap = 1000; temp_c = 8'sd25;
        idle(4);
        observe(FRAME, orv, c0, c1, ovl);
        chk("R4 bank A on-cycles per frame", c0, ON * TD);
        chk("R4 bank B on-cycles per frame", c1, ON * TD);

        // R2: hysteresis walk
        temp_c = -8'sd1;  idle(4); chk("R2 cold below 0", int'(gauge), 12);
        temp_c = 8'sd2;   idle(4); chk("R2 cold kept at 2", int'(gauge), 12);
        temp_c = 8'sd5;   idle(4); chk("R2 normal at 5", int'(gauge), 15);
        temp_c = 8'sd2;   idle(4); chk("R2 normal kept at 2", int'(gauge), 15);
        temp_c = -8'sd25; idle(4); chk("R2 frozen below -20", int'(gauge), 8);
        temp_c = 8'sd2;   idle(4); chk("R2 frozen relaxes to cold", int'(gauge), 12);
        temp_c = 8'sd25;  idle(4);

        // R5: enable sources and strap
        chg_show = 0;
        idle(3); observe(FRAME, orv, c0, c1, ovl);
        chk("R5 dark with no enable", int'(orv), 0);
        fast_dis = 1;
        idle(3); observe(FRAME, orv, c0, c1, ovl);
        chk("R5 fast discharge shows", int'(orv), 31);
        show_off = 1;
        idle(3); observe(FRAME, orv, c0, c1, ovl);
        chk("R5 strap blanks", int'(orv), 0);
        show_off = 0; fast_dis = 0;
        idle(3);

        // R6: button hold window
        btn_n = 0; idle(2); btn_n = 1;
        idle(2); observe(FRAME, orv, c0, c1, ovl);
        chk("R6 shown after press", int'(orv), 31);
        idle(70); observe(FRAME, orv, c0, c1, ovl);
        chk("R6 still shown late in window", int'(orv), 31);
        idle(16); observe(FRAME, orv, c0, c1, ovl);
        chk("R6 dark after window", int'(orv), 0);
        btn_n = 0; idle(200);
        observe(FRAME, orv, c0, c1, ovl);
        chk("R6 held low does not extend", int'(orv), 0);
        btn_n = 1; idle(2);

        // R7: blink of segment 1
        chg_show = 1; empty_flag = 1;
        idle(4); observe(4 * BT * TD, orv, c0, c1, ovl);
        chk("R7 empty flag blinks seg1", c0, 4 * ON * TD);
        chk("R7 seg2 steady", c1, 8 * ON * TD);
        empty_flag = 0; avail_chg = 50;
        idle(4); observe(4 * BT * TD, orv, c0, c1, ovl);
        chk("R7 below 10% blinks seg1", c0, 4 * ON * TD);
        avail_chg = 0;
        idle(4); observe(4 * BT * TD, orv, c0, c1, ovl);
        chk("R7 zero charge still blinks seg1", c0, 4 * ON * TD);
        chk("R7 zero charge others dark", int'(orv), 1);

        // R8: override bypass
        show_off = 1; ovr_reg = 8'hEB;
        idle(1); observe(FRAME, orv, c0, c1, ovl);
        chk("R8 override pattern", int'(orv), 5'b10101);
        chk("R8 override steady seg1", c0, FRAME);
        ovr_reg = 8'h00; show_off = 0;
        idle(1); observe(FRAME, orv, c0, c1, ovl);
        chk("R8 released to gauge", int'(orv), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule